// File: doc/BRIEF.md
# I/Q Data Quality Transition Detector

This block judges how clean an incoming FSK signal is. It looks at the sign bits of the in-phase and quadrature baseband paths of a zero-IF receiver and measures how regularly they rotate. A clean tone at the demodulator makes the {I,Q} pair step around the four quadrants in a single direction. Noise shows up as reversals of that rotation or as jumps across two quadrants at once. The block counts how long an unbroken run of same-direction quadrant steps lasts. At the end of every bit period it compares the longest run seen in that period with a programmable threshold and raises or lowers a one-bit quality flag.

Both sign inputs are asynchronous to the sample clock. Each passes through a two-flop synchronizer before any edge is detected. The bit-period tick comes from an external bit-rate divider and is one sample clock wide. A deviation close to the bit rate gives about four quadrant steps per bit. Lower bit rates give more steps, so the threshold reaches up to seven.

Top module: `iq_quality_detector`

## Requirements
- R1: After reset `dataGood` is low and the run count, the window peak and the direction memory are all cleared.
- R2: Both sign inputs pass through two synchronizer flops. A level change applied before clock edge n is first seen by a bit tick sampled at edge n+2. A tick at edge n+1 does not see it.
- R3: The quadrant phase of {I,Q} is 00=0, 01=1, 11=2, 10=3. A step of +1 (mod 4) is forward rotation. A forward step that follows a forward step adds one to the run count. The first step after a cleared direction only records the direction and leaves the run at zero.
- R4: A step of -1 (mod 4) is reverse rotation and is counted the same way as forward rotation.
- R5: A step opposite to the recorded direction sets the run count to zero and records the new direction.
- R6: A simultaneous change of I and Q (a step of 2) sets the run count to zero and forgets the direction. The next single step then counts as a first step.
- R7: At each bit tick, `dataGood` is set to (longest run within the closing period >= threshold). It holds that value until the next tick, whatever the inputs do in between.
- R8: Each bit tick clears the run count, the window peak and the direction memory, so the next period starts fresh.
- R9: The threshold is 3 bits. A value of 0 makes every tick report good. A value of 7 needs a run of seven, which is eight steps in one direction.
- R10: A step counted in the same cycle as a bit tick belongs to the closing period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| iSign | input | 1 | In-phase sign bit, asynchronous |
| qSign | input | 1 | Quadrature sign bit, asynchronous |
| bitTick | input | 1 | One-cycle strobe marking the end of a bit period |
| threshold | input | 3 | Minimum run length that counts as good data |
| dataGood | output | 1 | Quality flag, updated on each bit tick |

## Verification
The hardest situations to reach are the ones where a counting mistake stays hidden behind a correct-looking flag. Two cases matter most. In one, a direction memory survives a tick or a double-quadrant jump when it should have been cleared. In the other, a tick lands on the exact cycle in which a synchronized step becomes visible. The stimulus walks the bench's own quadrant phase one step at a time and sets the threshold exactly one above the correct peak. Any stale direction or missed reset then pushes the peak over the threshold and flips the flag. For the boundary case, the stimulus places the tick one edge before and then exactly at the cycle in which the synchronized change is counted.

// File: rtl/iq_quality_pkg.sv
package iq_quality_pkg;

  // Strobes from the rotation tracker to the run-count datapath
  typedef struct packed {
    logic incRun;       // step continues the recorded rotation
    logic zeroRun;      // first step, reversal or double jump
    logic closeWindow;  // bit period ends this cycle
  } dqStrobes_t;

  // Gray-ordered quadrant index of an {I,Q} sign pair
  function automatic logic [1:0] phaseOf(input logic iBit, input logic qBit);
    case ({iBit, qBit})
      2'b00:   phaseOf = 2'd0;
      2'b01:   phaseOf = 2'd1;
      2'b11:   phaseOf = 2'd2;
      default: phaseOf = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/iq_sync.sv
module iq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= '0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/iq_rotation_ctrl.sv
module iq_rotation_ctrl
  import iq_quality_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       iSync,
  input  logic       qSync,
  input  logic       bitTick,
  output dqStrobes_t strobes
);

  logic [1:0] prevPhase;
  logic [1:0] curPhase;
  logic [1:0] delta;
  logic       dirFwd;
  logic       dirValid;
  logic       stepFwd;
  logic       stepRev;
  logic       stepBad;

  always_comb begin
    curPhase = phaseOf(iSync, qSync);
    delta    = curPhase - prevPhase;
    stepFwd  = (delta == 2'd1);
    stepRev  = (delta == 2'd3);
    stepBad  = (delta == 2'd2);
  end

  always_comb begin
    strobes.incRun      = dirValid && ((stepFwd && dirFwd) || (stepRev && !dirFwd));
    strobes.zeroRun     = (stepFwd || stepRev || stepBad) && !strobes.incRun;
    strobes.closeWindow = bitTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPhase <= 2'd0;
      dirFwd    <= 1'b0;
      dirValid  <= 1'b0;
    end else begin
      prevPhase <= curPhase;
      if (bitTick || stepBad) begin
        dirValid <= 1'b0;
      end else if (stepFwd || stepRev) begin
        dirValid <= 1'b1;
        dirFwd   <= stepFwd;
      end
    end
  end

  // R8
  tick_forget_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> !dirValid);

  // R6
  jump_forget_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepBad |=> !dirValid);

  // R3
  step_learn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepFwd || stepRev) && !bitTick |=> dirValid && (dirFwd == $past(stepFwd)));

endmodule

// File: rtl/iq_run_datapath.sv
module iq_run_datapath
  import iq_quality_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int THR_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dqStrobes_t       strobes,
  input  logic [THR_W-1:0] threshold,
  output logic             dataGood
);

  localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run;
  logic [CNT_W-1:0] peak;
  logic [CNT_W-1:0] runUpd;
  logic [CNT_W-1:0] peakUpd;
  logic             meets;

  always_comb begin
    if (strobes.incRun)       runUpd = (run == RUN_MAX) ? run : run + 1'b1;
    else if (strobes.zeroRun) runUpd = '0;
    else                      runUpd = run;
    peakUpd = (runUpd > peak) ? runUpd : peak;
    meets   = (peakUpd >= CNT_W'(threshold));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run      <= '0;
      peak     <= '0;
      dataGood <= 1'b0;
    end else if (strobes.closeWindow) begin
      run      <= '0;
      peak     <= '0;
      dataGood <= meets;
    end else begin
      run      <= runUpd;
      peak     <= peakUpd;
    end
  end

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.closeWindow |=> $stable(dataGood));

  // R8
  window_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.closeWindow |=> (run == '0) && (peak == '0));

  // R5
  run_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.zeroRun && !strobes.closeWindow |=> run == '0);

  // R3
  run_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incRun && !strobes.closeWindow |=>
      (run == $past(run) + 1'b1) || (run == RUN_MAX && $past(run) == RUN_MAX));

  // R7
  peak_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    peak >= run);

  // R9
  zero_thr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.closeWindow && threshold == '0 |=> dataGood);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.incRun && strobes.zeroRun));

endmodule

// File: rtl/iq_quality_detector.sv
module iq_quality_detector
  import iq_quality_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int THR_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             iSign,
  input  logic             qSign,
  input  logic             bitTick,
  input  logic [THR_W-1:0] threshold,
  output logic             dataGood
);

  logic [1:0] iqSync;
  dqStrobes_t strobes;

  iq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({iSign, qSign}),
    .syncOut (iqSync)
  );

  iq_rotation_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .iSync   (iqSync[1]),
    .qSync   (iqSync[0]),
    .bitTick (bitTick),
    .strobes (strobes)
  );

  iq_run_datapath #(.CNT_W(CNT_W), .THR_W(THR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .threshold (threshold),
    .dataGood  (dataGood)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !dataGood);

endmodule

// File: tb/sim_iq_quality_detector.sv
module sim_iq_quality_detector;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       iSign = 1'b0;
  logic       qSign = 1'b0;
  logic       bitTick = 1'b0;
  logic [2:0] threshold = 3'd0;
  logic       dataGood;

  int checks = 0;
  int fails = 0;
  int curPh = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  iq_quality_detector u0 (
    .clk(clk), .rstN(rstN), .iSign(iSign), .qSign(qSign),
    .bitTick(bitTick), .threshold(threshold), .dataGood(dataGood)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dataGood=%0b expected %0b", req, act, exp);
    end
  endtask

  // drive quadrant index ph: 0=00 1=01 2=11 3=10
  task automatic drivePh(input int ph);
    curPh = ph & 3;
    case (curPh)
      0: {iSign, qSign} = 2'b00;
      1: {iSign, qSign} = 2'b01;
      2: {iSign, qSign} = 2'b11;
      default: {iSign, qSign} = 2'b10;
    endcase
  endtask

  // step by d (mod 4) and wait until it is counted
  task automatic step(input int d, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      drivePh(curPh + d);
      repeat (3) @(posedge clk);
    end
  endtask

  task automatic tickNow();
    @(negedge clk);
    bitTick = 1'b1;
    @(negedge clk);
    bitTick = 1'b0;
  endtask

  task automatic closeAndCheck(input string req, input logic exp);
    tickNow();
    check(req, dataGood, exp);
  endtask

  task automatic testReset();
    check("R1", dataGood, 1'b0);
    threshold = 3'd1;
    closeAndCheck("R1", 1'b0);
    threshold = 3'd0;
    closeAndCheck("R9", 1'b1);
    threshold = 3'd1;
    closeAndCheck("R7", 1'b0);
  endtask

  task automatic testForward();
    threshold = 3'd4;
    step(1, 5);
    closeAndCheck("R3", 1'b1);
    step(1, 4);
    closeAndCheck("R8", 1'b0);
  endtask

  task automatic testReverse();
    threshold = 3'd7;
    step(-1, 8);
    closeAndCheck("R4", 1'b1);
    step(-1, 7);
    closeAndCheck("R9", 1'b0);
  endtask

  task automatic testReversal();
    threshold = 3'd3;
    step(1, 3);
    step(-1, 3);
    closeAndCheck("R5", 1'b0);
    threshold = 3'd4;
    step(1, 5);
    step(-1, 2);
    closeAndCheck("R7", 1'b1);
  endtask

  task automatic testJump();
    threshold = 3'd3;
    step(1, 3);
    step(2, 1);
    step(1, 3);
    closeAndCheck("R6", 1'b0);
  endtask

  task automatic testTiming();
    threshold = 3'd1;
    step(1, 1);
    @(negedge clk);
    drivePh(curPh + 1);
    @(posedge clk);
    @(negedge clk);
    bitTick = 1'b1;
    @(negedge clk);
    bitTick = 1'b0;
    check("R2", dataGood, 1'b0);
    repeat (3) @(posedge clk);
    closeAndCheck("R8", 1'b0);
    step(1, 1);
    @(negedge clk);
    drivePh(curPh + 1);
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    bitTick = 1'b1;
    @(negedge clk);
    bitTick = 1'b0;
    check("R10", dataGood, 1'b1);
    repeat (3) @(posedge clk);
  endtask

  task automatic testHold();
    threshold = 3'd2;
    step(1, 3);
    closeAndCheck("R7", 1'b1);
    step(2, 2);
    step(-1, 2);
    check("R7", dataGood, 1'b1);
    closeAndCheck("R7", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testForward();
    testReverse();
    testReversal();
    testJump();
    testTiming();
    testHold();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule